// File: doc/BRIEF.md
# Lost-Reply Recovery Controller

This block sits beside a multi-context processor's memory interface. It spots the case where a context's shared-memory reply keeps getting evicted or invalidated before the load or store can retire. It does not try to stop the loss in advance. Instead it detects the loss after the fact and then forces progress.

Each outstanding access slot of each hardware context owns a "tried" flag. The flag is raised on the first attempt that misses. When the context comes back to the same slot, the flag is still set, the transaction tracker reports completion, and the data is not there, the reply has been lost. The controller then enters a spin phase:
- context switching is held off,
- a per-slot lock bit is raised, so that every incoming invalidation is parked,
- a one-cycle event pulse is emitted, which also asks for the access to be reissued,
- a wrapping event counter advances.

The spin phase ends when the recovering slot commits. Parked invalidations then drain to the cache, oldest first. The parking queue holds off its sender when it is full. Interrupt handlers may run during the lock, provided they return to the interrupted context; this block does not observe them.

Top module: `thrash_ctl`

## Requirements
- R1: After reset, every tried flag, `cs_disable`, `inv_defer`, `lock_bits` and `thrash_pulse` are 0. `thrash_count` is 0 and `inv_ready` is 1.
- R2: An attempt (`att_valid`) with `att_miss` high sets tried flag `tried_once[att_ctx*NSLOT + att_slot]` after the clock edge.
- R3: An attempt with `att_miss`, a set tried flag, `att_done` high and `att_data` low, made while not spinning, takes effect one edge later. `cs_disable` and `inv_defer` go high, and only `lock_bits[att_slot]` is set. `thrash_pulse` is high for exactly that cycle, and `thrash_count` grows by one.
- R4: No detection occurs if the tried flag was clear before the attempt, if `att_done` is low, or if `att_data` is high.
- R5: A commit (`commit_valid`) clears the addressed tried flag after the edge, and a commit wins over a same-cycle set of that flag. A commit of the spinning context and slot drops `cs_disable`, `inv_defer` and `lock_bits` after the same edge.
- R6: While spinning, further qualifying attempts cause no pulse and leave `thrash_count` unchanged.
- R7: Accepted invalidations leave on `inv_out_valid`/`inv_out_addr` in arrival order, one per cycle, at the earliest one cycle after acceptance, and never while `inv_defer` is high.
- R8: `inv_ready` is low exactly when FDEPTH invalidations are parked. An invalidation offered while `inv_ready` is low is dropped.
- R9: `thrash_count` wraps to 0 after reaching 2^CNTW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| att_valid | input | 1 | A context is attempting a shared-memory access |
| att_miss | input | 1 | The attempt missed (the data was not usable) |
| att_done | input | 1 | The transaction tracker reports the reply as arrived |
| att_data | input | 1 | The reply data is present |
| att_ctx | input | CW | Attempting context |
| att_slot | input | SW | Outstanding-access slot of the attempt |
| commit_valid | input | 1 | An access has retired |
| commit_ctx | input | CW | Context of the retiring access |
| commit_slot | input | SW | Slot of the retiring access |
| inv_valid | input | 1 | External invalidation offered |
| inv_addr | input | AW | Address of the offered invalidation |
| inv_ready | output | 1 | Invalidation queue can accept |
| inv_out_valid | output | 1 | Invalidation forwarded to the cache this cycle |
| inv_out_addr | output | AW | Address of the forwarded invalidation |
| cs_disable | output | 1 | Context switching held off |
| inv_defer | output | 1 | Invalidations being parked |
| lock_bits | output | NSLOT | Per-slot lock; the bit of the spinning slot is high |
| tried_once | output | NCTX*NSLOT | Tried flags, index ctx*NSLOT+slot |
| thrash_pulse | output | 1 | One-cycle detection event and reissue request |
| thrash_count | output | CNTW | Wrapping detection counter |

## Verification
The bench builds the block with four contexts of two slots each, a four-entry invalidation queue and a four-bit event counter. The narrow counter brings wrap-around within reach of a short random run. The shallow queue fills during most spin phases, so backpressure and dropped offers are exercised often. Commits are steered toward the spinning slot half the time, so the bench sees many entries into and exits from the spin phase. It also sees attempts collide with commits on the same flag.

// File: rtl/thrash_ctl_pkg.sv
package thrash_ctl_pkg;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_SPIN = 1'b1
   } rec_state_e;

   // A retry found its reply gone: already tried, transaction done, data absent.
   function automatic logic reply_lost(input logic miss, input logic tried,
                                       input logic done, input logic data);
      return miss && tried && done && !data;
   endfunction

endpackage

// File: rtl/tro_bank.sv
module tro_bank #(
   parameter int NCTX  = 4,
   parameter int NSLOT = 2,
   parameter int CW    = 2,
   parameter int SW    = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [CW-1:0]          set_ctx,
   input  logic [SW-1:0]          set_slot,
   input  logic                   clr_en,
   input  logic [CW-1:0]          clr_ctx,
   input  logic [SW-1:0]          clr_slot,
   output logic [NCTX*NSLOT-1:0]  bits
);

   for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         logic hit_set, hit_clr;
         assign hit_set = set_en && (set_ctx == CW'(c)) && (set_slot == SW'(s));
         assign hit_clr = clr_en && (clr_ctx == CW'(c)) && (clr_slot == SW'(s));
         always_ff @(posedge clk) begin
            if (!rst_n)       bits[c*NSLOT+s] <= 1'b0;
            else if (hit_clr) bits[c*NSLOT+s] <= 1'b0;
            else if (hit_set) bits[c*NSLOT+s] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/recov_ctl.sv
module recov_ctl
   import thrash_ctl_pkg::*;
#(
   parameter int CW      = 2,
   parameter int SW      = 1,
   parameter int CNTW    = 8,
   parameter bit CNT_SAT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            att_valid,
   input  logic            att_miss,
   input  logic            att_done,
   input  logic            att_data,
   input  logic            tried_hit,
   input  logic [CW-1:0]   att_ctx,
   input  logic [SW-1:0]   att_slot,
   input  logic            commit_valid,
   input  logic [CW-1:0]   commit_ctx,
   input  logic [SW-1:0]   commit_slot,
   output logic            spinning,
   output logic [SW-1:0]   spin_slot,
   output logic            pulse,
   output logic [CNTW-1:0] count
);

   rec_state_e    st;
   logic [CW-1:0] spin_ctx;
   logic          detect, release_hit;

   assign detect      = att_valid && (st == ST_RUN) &&
                        reply_lost(att_miss, tried_hit, att_done, att_data);
   assign release_hit = (st == ST_SPIN) && commit_valid &&
                        (commit_ctx == spin_ctx) && (commit_slot == spin_slot);
   assign spinning    = (st == ST_SPIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         spin_ctx  <= '0;
         spin_slot <= '0;
         pulse     <= 1'b0;
      end else begin
         pulse <= detect;
         if (detect) begin
            st        <= ST_SPIN;
            spin_ctx  <= att_ctx;
            spin_slot <= att_slot;
         end else if (release_hit) begin
            st <= ST_RUN;
         end
      end
   end

   if (CNT_SAT) begin : g_cnt_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                    count <= '0;
         else if (detect && count != '1) count <= count + 1'b1;
      end
   end else begin : g_cnt_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)      count <= '0;
         else if (detect) count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/inv_defer_q.sv
module inv_defer_q #(
   parameter int AW    = 16,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [AW-1:0] in_addr,
   output logic          in_ready,
   input  logic          hold,
   output logic          out_valid,
   output logic [AW-1:0] out_addr
);

   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW:0]   fill;
   logic          push, pop;

   assign in_ready  = (fill != (PW+1)'(DEPTH));
   assign out_valid = (fill != '0) && !hold;
   assign out_addr  = mem[rd_ptr];
   assign push      = in_valid && in_ready;
   assign pop       = out_valid;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= in_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + (PW+1)'(push) - (PW+1)'(pop);
      end
   end

endmodule

// File: rtl/thrash_ctl.sv
module thrash_ctl #(
   parameter int NCTX    = 4,
   parameter int NSLOT   = 2,
   parameter int AW      = 16,
   parameter int FDEPTH  = 4,
   parameter int CNTW    = 8,
   parameter bit CNT_SAT = 1'b0,
   localparam int CW     = (NCTX > 1) ? $clog2(NCTX) : 1,
   localparam int SW     = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int NT     = NCTX * NSLOT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            att_valid,
   input  logic            att_miss,
   input  logic            att_done,
   input  logic            att_data,
   input  logic [CW-1:0]   att_ctx,
   input  logic [SW-1:0]   att_slot,
   input  logic            commit_valid,
   input  logic [CW-1:0]   commit_ctx,
   input  logic [SW-1:0]   commit_slot,
   input  logic            inv_valid,
   input  logic [AW-1:0]   inv_addr,
   output logic            inv_ready,
   output logic            inv_out_valid,
   output logic [AW-1:0]   inv_out_addr,
   output logic            cs_disable,
   output logic            inv_defer,
   output logic [NSLOT-1:0] lock_bits,
   output logic [NT-1:0]   tried_once,
   output logic            thrash_pulse,
   output logic [CNTW-1:0] thrash_count
);

   if (NCTX < 1 || NSLOT < 1) begin : g_bad_shape
      $error("thrash_ctl: NCTX and NSLOT must be at least 1");
   end
   if (FDEPTH < 2 || (FDEPTH & (FDEPTH - 1)) != 0) begin : g_bad_depth
      $error("thrash_ctl: FDEPTH must be a power of two, at least 2");
   end
   if (AW < 1 || CNTW < 1) begin : g_bad_width
      $error("thrash_ctl: AW and CNTW must be at least 1");
   end

   logic          tried_hit, spinning;
   logic [SW-1:0] spin_slot;
   int            att_idx;

   assign att_idx = int'(att_ctx) * NSLOT + int'(att_slot);

   always_comb begin
      tried_hit = 1'b0;
      for (int i = 0; i < NT; i++) begin
         if (i == att_idx) tried_hit = tried_once[i];
      end
   end

   tro_bank #(.NCTX(NCTX), .NSLOT(NSLOT), .CW(CW), .SW(SW)) u_tro (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (att_valid && att_miss),
      .set_ctx  (att_ctx),
      .set_slot (att_slot),
      .clr_en   (commit_valid),
      .clr_ctx  (commit_ctx),
      .clr_slot (commit_slot),
      .bits     (tried_once)
   );

   recov_ctl #(.CW(CW), .SW(SW), .CNTW(CNTW), .CNT_SAT(CNT_SAT)) u_rec (
      .clk          (clk),
      .rst_n        (rst_n),
      .att_valid    (att_valid),
      .att_miss     (att_miss),
      .att_done     (att_done),
      .att_data     (att_data),
      .tried_hit    (tried_hit),
      .att_ctx      (att_ctx),
      .att_slot     (att_slot),
      .commit_valid (commit_valid),
      .commit_ctx   (commit_ctx),
      .commit_slot  (commit_slot),
      .spinning     (spinning),
      .spin_slot    (spin_slot),
      .pulse        (thrash_pulse),
      .count        (thrash_count)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_lock
      assign lock_bits[s] = spinning && (spin_slot == SW'(s));
   end

   assign cs_disable = spinning;
   assign inv_defer  = |lock_bits;

   inv_defer_q #(.AW(AW), .DEPTH(FDEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (inv_valid),
      .in_addr   (inv_addr),
      .in_ready  (inv_ready),
      .hold      (inv_defer),
      .out_valid (inv_out_valid),
      .out_addr  (inv_out_addr)
   );

endmodule

// File: rtl/thrash_ctl_chk.sv
module thrash_ctl_chk #(
   parameter int NSLOT  = 2,
   parameter int FDEPTH = 4,
   parameter int CNTW   = 8,
   localparam int PW    = $clog2(FDEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inv_valid,
   input logic             inv_ready,
   input logic             inv_out_valid,
   input logic             cs_disable,
   input logic             inv_defer,
   input logic [NSLOT-1:0] lock_bits,
   input logic             thrash_pulse,
   input logic [CNTW-1:0]  thrash_count
);

   logic [PW:0] occ;

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + (PW+1)'(inv_valid && inv_ready) - (PW+1)'(inv_out_valid);
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ <= (PW+1)'(FDEPTH)) && (!inv_ready == (occ == (PW+1)'(FDEPTH))));

   p_defer_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_out_valid |-> !inv_defer);

   p_lock_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lock_bits));

   p_pulse_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      thrash_pulse |-> (cs_disable && inv_defer));

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      thrash_pulse |-> (thrash_count == CNTW'($past(thrash_count) + 1'b1)));

   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      thrash_pulse |=> !thrash_pulse);

   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !thrash_pulse |-> $stable(thrash_count));

endmodule

bind thrash_ctl thrash_ctl_chk #(.NSLOT(NSLOT), .FDEPTH(FDEPTH), .CNTW(CNTW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .inv_valid     (inv_valid),
   .inv_ready     (inv_ready),
   .inv_out_valid (inv_out_valid),
   .cs_disable    (cs_disable),
   .inv_defer     (inv_defer),
   .lock_bits     (lock_bits),
   .thrash_pulse  (thrash_pulse),
   .thrash_count  (thrash_count)
);

// File: tb/thrash_ctl_test.sv
module thrash_ctl_test;

   localparam int NCTX = 4, NSLOT = 2, AW = 8, FDEPTH = 4, CNTW = 4;
   localparam int NT = NCTX * NSLOT;

   logic clk = 1'b0, rst_n = 1'b0;
   logic att_valid = 0, att_miss = 0, att_done = 0, att_data = 0;
   logic [1:0] att_ctx = 0, commit_ctx = 0;
   logic [0:0] att_slot = 0, commit_slot = 0;
   logic commit_valid = 0, inv_valid = 0;
   logic [AW-1:0] inv_addr = 0;
   logic inv_ready, inv_out_valid, cs_disable, inv_defer, thrash_pulse;
   logic [AW-1:0] inv_out_addr;
   logic [NSLOT-1:0] lock_bits;
   logic [NT-1:0] tried_once;
   logic [CNTW-1:0] thrash_count;

   always #4 clk = ~clk;

   thrash_ctl #(.NCTX(NCTX), .NSLOT(NSLOT), .AW(AW), .FDEPTH(FDEPTH), .CNTW(CNTW)) uut (
      .clk(clk), .rst_n(rst_n), .att_valid(att_valid), .att_miss(att_miss),
      .att_done(att_done), .att_data(att_data), .att_ctx(att_ctx), .att_slot(att_slot),
      .commit_valid(commit_valid), .commit_ctx(commit_ctx), .commit_slot(commit_slot),
      .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready),
      .inv_out_valid(inv_out_valid), .inv_out_addr(inv_out_addr), .cs_disable(cs_disable),
      .inv_defer(inv_defer), .lock_bits(lock_bits), .tried_once(tried_once),
      .thrash_pulse(thrash_pulse), .thrash_count(thrash_count));

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   // reference state, built from the requirements
   logic [NT-1:0] m_tried = '0;
   bit m_rec = 0, m_pulse = 0;
   int m_rctx = 0, m_rslot = 0, m_cnt = 0;
   logic [AW-1:0] m_q[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [NSLOT-1:0] exp_lock();
      return m_rec ? NSLOT'(1 << m_rslot) : '0;
   endfunction

   function automatic bit exp_out_valid();
      return (m_q.size() > 0) && !m_rec;
   endfunction

   task automatic compare_all();
      chk(tried_once == m_tried, "R2 tried flags", 32'(tried_once), 32'(m_tried));
      chk(cs_disable == m_rec, "R5 cs_disable", 32'(cs_disable), 32'(m_rec));
      chk(inv_defer == m_rec, "R3 inv_defer", 32'(inv_defer), 32'(m_rec));
      chk(lock_bits == exp_lock(), "R3 lock_bits", 32'(lock_bits), 32'(exp_lock()));
      chk(thrash_pulse == m_pulse, "R3 thrash_pulse", 32'(thrash_pulse), 32'(m_pulse));
      chk(thrash_count == CNTW'(m_cnt), "R9 thrash_count", 32'(thrash_count), 32'(CNTW'(m_cnt)));
      chk(inv_ready == (m_q.size() < FDEPTH), "R8 inv_ready", 32'(inv_ready), 32'(m_q.size() < FDEPTH));
      chk(inv_out_valid == exp_out_valid(), "R7 inv_out_valid", 32'(inv_out_valid), 32'(exp_out_valid()));
      if (exp_out_valid())
         chk(inv_out_addr == m_q[0], "R7 inv_out_addr order", 32'(inv_out_addr), 32'(m_q[0]));
   endtask

   task automatic step(input bit av, input bit am, input bit ad, input bit adat,
                       input int actx, input int aslot,
                       input bit cv, input int cctx, input int cslot,
                       input bit iv, input logic [AW-1:0] ia);
      int ai, ci;
      bit det, rel, pop, push;
      @(negedge clk);
      compare_all();
      att_valid = av; att_miss = am; att_done = ad; att_data = adat;
      att_ctx = 2'(actx); att_slot = 1'(aslot);
      commit_valid = cv; commit_ctx = 2'(cctx); commit_slot = 1'(cslot);
      inv_valid = iv; inv_addr = ia;
      ai = actx * NSLOT + aslot;
      ci = cctx * NSLOT + cslot;
      det  = av && am && m_tried[ai] && ad && !adat && !m_rec;
      rel  = m_rec && cv && (cctx == m_rctx) && (cslot == m_rslot);
      pop  = (m_q.size() > 0) && !m_rec;
      push = iv && (m_q.size() < FDEPTH);
      if (av && am) m_tried[ai] = 1'b1;
      if (cv) m_tried[ci] = 1'b0;
      m_pulse = det;
      if (det) begin
         m_rec = 1; m_rctx = actx; m_rslot = aslot; m_cnt++;
      end else if (rel) begin
         m_rec = 0;
      end
      if (pop) void'(m_q.pop_front());
      if (push) m_q.push_back(ia);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
   endtask

   task automatic settle();
      @(posedge clk);
      #2;
   endtask

   initial begin
      void'($urandom(32'h1d2c_0417));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(tried_once == '0, "R1 tried after reset", 32'(tried_once), 0);
      chk(!cs_disable && !inv_defer && lock_bits == '0, "R1 locks after reset", 32'(cs_disable), 0);
      chk(thrash_count == '0 && !thrash_pulse, "R1 counter after reset", 32'(thrash_count), 0);
      chk(inv_ready && !inv_out_valid, "R1 queue after reset", 32'(inv_ready), 1);

      // R2: first missing attempt on ctx1 slot0 sets flag index 2
      step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, '0); settle();
      chk(tried_once[2] == 1'b1, "R2 flag ctx1 slot0", 32'(tried_once), 32'h4);
      // R4: retry with transaction not done
      step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, '0); settle();
      chk(!thrash_pulse && !cs_disable, "R4 not done", 32'(thrash_pulse), 0);
      // R4: retry with data present
      step(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, '0); settle();
      chk(!thrash_pulse && !cs_disable, "R4 data present", 32'(thrash_pulse), 0);
      // R4: first attempt on ctx2 slot1 that looks lost, flag was clear
      step(1, 1, 1, 0, 2, 1, 0, 0, 0, 0, '0); settle();
      chk(!thrash_pulse && tried_once[5], "R4 first attempt", 32'(tried_once), 32'h24);
      // R3: lost reply on ctx1 slot0
      step(1, 1, 1, 0, 1, 0, 0, 0, 0, 0, '0); settle();
      chk(thrash_pulse && cs_disable && inv_defer, "R3 detect", 32'(thrash_pulse), 1);
      chk(lock_bits == 2'b01 && thrash_count == 4'd1, "R3 lock slot0 count", 32'(lock_bits), 1);
      // R6: second lost reply while spinning
      step(1, 1, 1, 0, 2, 1, 0, 0, 0, 0, '0); settle();
      chk(!thrash_pulse && thrash_count == 4'd1, "R6 ignored while spinning", 32'(thrash_count), 1);
      // R8/R7: park five invalidations while locked
      for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, AW'(8'h11 + k));
      settle();
      chk(!inv_ready, "R8 queue full", 32'(inv_ready), 0);
      chk(!inv_out_valid, "R7 parked while locked", 32'(inv_out_valid), 0);
      // R5: commit of the spinning slot releases
      step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, '0); settle();
      chk(!cs_disable && lock_bits == '0 && !tried_once[2], "R5 release", 32'(cs_disable), 0);
      chk(inv_out_valid && inv_out_addr == 8'h11, "R7 oldest first", 32'(inv_out_addr), 32'h11);
      for (int k = 0; k < 6; k++) idle();

      // random phase
      for (int n = 0; n < 15000; n++) begin
         bit av, am, ad, adat, cv, iv;
         int actx, aslot, cctx, cslot;
         av = ($urandom % 2) == 0;
         am = ($urandom % 10) < 7;
         ad = ($urandom % 2) == 0;
         adat = ($urandom % 10) < 3;
         actx = $urandom % NCTX;
         aslot = $urandom % NSLOT;
         cv = ($urandom % 5) == 0;
         if (m_rec && ($urandom % 2) == 0) begin
            cctx = m_rctx; cslot = m_rslot;
         end else begin
            cctx = $urandom % NCTX; cslot = $urandom % NSLOT;
         end
         iv = ($urandom % 10) < 3;
         step(av, am, ad, adat, actx, aslot, cv, cctx, cslot, iv, AW'($urandom));
      end
      idle();
      chk(m_cnt > (1 << CNTW), "R9 wrap reached", 32'(m_cnt), 32'(1 << CNTW));
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule